// File: doc/BRIEF.md
# Display serial link command packet builder

This block turns one command request at a time into a display serial link command packet and hands the resulting 32-bit words to one of two FIFO pairs: a high-speed pair or a low-power pair, picked per request. A short packet (generic write, generic read, display command write or display command read) becomes a single header word. A long packet (generic or display command long write) first takes its payload as a byte stream. It packs the bytes four to a word, least significant lane first, and writes every payload word to the data FIFO. Only then does it write a header word to the control FIFO, and that header holds the byte count.

Every data path uses valid/ready. A request is taken when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` is high only while the block is idle. A payload byte moves when `pay_valid` and `pay_ready` are both high. Each FIFO is written when its valid and its ready are both high. Once a valid is raised, it and its word stay unchanged until the FIFO accepts the word, however long ready stays low. Bytes offered while `pay_ready` is low are left in place. A request that cannot be built produces a one-cycle `req_err` pulse and writes nothing.

Top module: `dsi_cmd_packer`

## Requirements
- R1: Data type codes select the packet form. Short with no argument: 0x03 and 0x04. Short with one argument: 0x13, 0x14, 0x05 and 0x06. Short with two arguments: 0x23, 0x24 and 0x15. Long: 0x29 and 0x39. Any other code is rejected in the same way as R11.
- R2: The short header word is {8'h00, arg1, arg0, vc[1:0], type[5:0]}: the type is in bits 5:0, arg0 in bits 15:8 and arg1 in bits 23:16.
- R3: In a short header, an argument byte that the type does not use is driven as zero, whatever value the request carries.
- R4: The long header word is {8'h00, len[15:0], vc[1:0], type[5:0]}, with the payload byte count in bits 23:8.
- R5: Payload byte n of a long packet goes to word n/4, in bits 8*(n%4)+7 down to 8*(n%4).
- R6: When the length is not a multiple of four, the last payload word carries the remaining bytes in its low lanes and zeros above them. A long packet gives exactly ceil(len/4) data words.
- R7: Every payload word of a packet is written to the data FIFO before its header word is written to the control FIFO.
- R8: The virtual channel field, bits 7:6, is always zero, and bits 31:24 of every header are zero.
- R9: When `req_hs` is 1 at acceptance, the packet's words go only to the high-speed valids. When it is 0, they go only to the low-power valids.
- R10: `req_ready` is 1 only while idle. It goes low in the cycle after acceptance and returns to 1 in the cycle after the header word is written.
- R11: A long request with length 0, or a request with an unknown type, makes `req_err` high for one cycle, leaves `req_ready` high and causes no FIFO write.
- R12: While a valid is high and its ready is low, the valid stays high and the word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_type | input | 6 | Packet data type code |
| req_arg0 | input | 8 | First argument / command byte |
| req_arg1 | input | 8 | Second argument byte |
| req_len | input | 16 | Long packet payload byte count |
| req_hs | input | 1 | 1 = high-speed FIFO pair, 0 = low-power pair |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte can be taken |
| pay_byte | input | 8 | Payload byte |
| hs_dat_valid | output | 1 | Word for the high-speed data FIFO |
| hs_dat_ready | input | 1 | High-speed data FIFO has room |
| lp_dat_valid | output | 1 | Word for the low-power data FIFO |
| lp_dat_ready | input | 1 | Low-power data FIFO has room |
| dat_word | output | 32 | Payload word |
| hs_ctl_valid | output | 1 | Header for the high-speed control FIFO |
| hs_ctl_ready | input | 1 | High-speed control FIFO has room |
| lp_ctl_valid | output | 1 | Header for the low-power control FIFO |
| lp_ctl_ready | input | 1 | Low-power control FIFO has room |
| ctl_word | output | 32 | Header word |
| req_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions check, on every cycle, the parts of the protocol that hold at all times. Words stay stable under back-pressure, and data and control words are never offered together. At most one path is active. `req_ready` stays low while any word is pending and comes back after the header is written. Header bits 31:24 and the channel field are zero, and a rejection is never followed by a header. Only the bench scenarios can show that the values are right: the header fields for each type class, the zeroing of unused arguments, the lane order of the payload bytes, the zero fill and word count for every remainder of the length modulo four, and which path each packet took.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;
  localparam logic [1:0] VCHAN = 2'b00;

  typedef enum logic [1:0] {ST_IDLE, ST_PACK, ST_HDR} state_t;
  typedef enum logic [2:0] {K_BAD, K_ARG0, K_ARG1, K_ARG2, K_LONG} kind_t;

  function automatic kind_t classify(input logic [5:0] t);
    case (t)
      6'h03, 6'h04:               classify = K_ARG0;
      6'h13, 6'h14, 6'h05, 6'h06: classify = K_ARG1;
      6'h23, 6'h24, 6'h15:        classify = K_ARG2;
      6'h29, 6'h39:               classify = K_LONG;
      default:                    classify = K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/dsi_hdr_fmt.sv
module dsi_hdr_fmt
  import dsi_cmd_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic [5:0]        typ,
  input  logic [7:0]        arg0,
  input  logic [7:0]        arg1,
  input  logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - 24;

  kind_t kind;
  assign kind = classify(typ);

  always_comb begin
    case (kind)
      K_LONG:  word = {{PAD_W{1'b0}}, 16'(len), VCHAN, typ};
      K_ARG2:  word = {{PAD_W{1'b0}}, arg1, arg0, VCHAN, typ};
      K_ARG1:  word = {{PAD_W{1'b0}}, 8'h00, arg0, VCHAN, typ};
      default: word = {{PAD_W{1'b0}}, 16'h0000, VCHAN, typ};
    endcase
  end
endmodule

// File: rtl/dsi_byte_packer.sv
module dsi_byte_packer #(
  parameter int LEN_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              done
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic              active, full;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  remain;
  logic [WORD_W-1:0] word;

  assign in_ready  = active && !full;
  assign out_valid = full;
  assign out_word  = word;
  assign done      = full && out_ready && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      full   <= 1'b0;
      lane   <= '0;
      remain <= '0;
      word   <= '0;
    end else if (start) begin
      active <= 1'b1;
      full   <= 1'b0;
      lane   <= '0;
      remain <= len;
      word   <= '0;
    end else if (full) begin
      if (out_ready) begin
        full <= 1'b0;
        lane <= '0;
        word <= '0;
        if (remain == '0) active <= 1'b0;
      end
    end else if (in_valid && in_ready) begin
      word[{lane, 3'b000} +: 8] <= in_byte;
      lane   <= lane + 1'b1;
      remain <= remain - 1'b1;
      if (lane == LANE_W'(LANES - 1) || remain == LEN_W'(1)) full <= 1'b1;
    end
  end
endmodule

// File: rtl/dsi_cmd_packer.sv
module dsi_cmd_packer
  import dsi_cmd_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [5:0]        req_type,
  input  logic [7:0]        req_arg0,
  input  logic [7:0]        req_arg1,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_hs,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_byte,
  output logic              hs_dat_valid,
  input  logic              hs_dat_ready,
  output logic              lp_dat_valid,
  input  logic              lp_dat_ready,
  output logic [WORD_W-1:0] dat_word,
  output logic              hs_ctl_valid,
  input  logic              hs_ctl_ready,
  output logic              lp_ctl_valid,
  input  logic              lp_ctl_ready,
  output logic [WORD_W-1:0] ctl_word,
  output logic              req_err
);
  state_t           st;
  kind_t            in_kind;
  logic             accept, bad, sel_hs, err_q;
  logic [5:0]       l_type;
  logic [7:0]       l_arg0, l_arg1;
  logic [LEN_W-1:0] l_len;
  logic             pk_start, pk_valid, pk_ready, pk_done, ctl_fire;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_kind   = classify(req_type);
  assign bad       = (in_kind == K_BAD) || (in_kind == K_LONG && req_len == '0);
  assign pk_start  = accept && !bad && (in_kind == K_LONG);
  assign req_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err_q  <= 1'b0;
      sel_hs <= 1'b0;
      l_type <= '0;
      l_arg0 <= '0;
      l_arg1 <= '0;
      l_len  <= '0;
    end else begin
      err_q <= accept && bad;
      case (st)
        ST_IDLE: if (accept && !bad) begin
          sel_hs <= req_hs;
          l_type <= req_type;
          l_arg0 <= req_arg0;
          l_arg1 <= req_arg1;
          l_len  <= req_len;
          st     <= (in_kind == K_LONG) ? ST_PACK : ST_HDR;
        end
        ST_PACK: if (pk_done) st <= ST_HDR;
        ST_HDR:  if (ctl_fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  dsi_byte_packer #(.LEN_W(LEN_W), .WORD_W(WORD_W)) packer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (pk_start),
    .len      (req_len),
    .in_valid (pay_valid),
    .in_ready (pay_ready),
    .in_byte  (pay_byte),
    .out_valid(pk_valid),
    .out_ready(pk_ready),
    .out_word (dat_word),
    .done     (pk_done)
  );

  dsi_hdr_fmt #(.LEN_W(LEN_W), .WORD_W(WORD_W)) hdr_i (
    .typ (l_type),
    .arg0(l_arg0),
    .arg1(l_arg1),
    .len (l_len),
    .word(ctl_word)
  );

  assign pk_ready     = sel_hs ? hs_dat_ready : lp_dat_ready;
  assign hs_dat_valid = pk_valid && sel_hs;
  assign lp_dat_valid = pk_valid && !sel_hs;
  assign hs_ctl_valid = (st == ST_HDR) && sel_hs;
  assign lp_ctl_valid = (st == ST_HDR) && !sel_hs;
  assign ctl_fire     = (hs_ctl_valid && hs_ctl_ready) || (lp_ctl_valid && lp_ctl_ready);
endmodule

// File: rtl/dsi_cmd_packer_chk.sv
module dsi_cmd_packer_chk #(
  parameter int LEN_W  = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              hs_dat_valid,
  input logic              hs_dat_ready,
  input logic              lp_dat_valid,
  input logic              lp_dat_ready,
  input logic [WORD_W-1:0] dat_word,
  input logic              hs_ctl_valid,
  input logic              hs_ctl_ready,
  input logic              lp_ctl_valid,
  input logic              lp_ctl_ready,
  input logic [WORD_W-1:0] ctl_word,
  input logic              req_err
);
  logic any_dat, any_ctl, ctl_fire;
  assign any_dat  = hs_dat_valid || lp_dat_valid;
  assign any_ctl  = hs_ctl_valid || lp_ctl_valid;
  assign ctl_fire = (hs_ctl_valid && hs_ctl_ready) || (lp_ctl_valid && lp_ctl_ready);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_dat || any_ctl) |-> !req_ready);
  // R10
  ready_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire |=> req_ready);
  // R7
  dat_ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_dat && any_ctl));
  // R9
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_dat_valid && lp_dat_valid) && !(hs_ctl_valid && lp_ctl_valid));
  // R12
  hs_dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_dat_valid && !hs_dat_ready) |=> (hs_dat_valid && $stable(dat_word)));
  // R12
  lp_dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_dat_valid && !lp_dat_ready) |=> (lp_dat_valid && $stable(dat_word)));
  // R12
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ctl && !ctl_fire) |=> (any_ctl && $stable(ctl_word)));
  // R8
  hdr_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_ctl |-> (ctl_word[7:6] == 2'b00 && ctl_word[WORD_W-1:24] == '0));
  // R11
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !any_dat && !any_ctl));
endmodule

bind dsi_cmd_packer dsi_cmd_packer_chk #(.LEN_W(LEN_W), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/dsi_cmd_packer_tb_top.sv
module dsi_cmd_packer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_hs = 0, pay_valid = 0;
  logic [5:0]  req_type = 0;
  logic [7:0]  req_arg0 = 0, req_arg1 = 0, pay_byte = 0;
  logic [15:0] req_len = 0;
  logic        hs_dat_ready, lp_dat_ready;
  logic        hs_ctl_ready = 1, lp_ctl_ready = 1;
  logic        req_ready, pay_ready, hs_dat_valid, lp_dat_valid, hs_ctl_valid, lp_ctl_valid, req_err;
  logic [31:0] dat_word, ctl_word;

  dsi_cmd_packer dut_i (.*);

  int checks = 0, errors = 0;
  bit stall = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc++;
    hs_dat_ready <= stall ? cyc[1] : 1'b1;
    lp_dat_ready <= stall ? cyc[1] : 1'b1;
  end

  logic [31:0] dw [0:255];
  bit          dp [0:255];
  logic [31:0] cw [0:63];
  bit          cp [0:63];
  int          cd [0:63];
  int dcnt = 0, ccnt = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (hs_dat_valid && hs_dat_ready) begin dw[dcnt] = dat_word; dp[dcnt] = 1; dcnt++; end
      if (lp_dat_valid && lp_dat_ready) begin dw[dcnt] = dat_word; dp[dcnt] = 0; dcnt++; end
      if (hs_ctl_valid && hs_ctl_ready) begin cw[ccnt] = ctl_word; cp[ccnt] = 1; cd[ccnt] = dcnt; ccnt++; end
      if (lp_ctl_valid && lp_ctl_ready) begin cw[ccnt] = ctl_word; cp[ccnt] = 0; cd[ccnt] = dcnt; ccnt++; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int n);
    return seed + 8'(n * 7);
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int len, input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = pbyte(seed, 4 * k + j);
    return w;
  endfunction

  task automatic issue(input logic [5:0] t, input logic [7:0] a0, input logic [7:0] a1,
                       input logic [15:0] len, input bit hs);
    @(negedge clk);
    req_valid = 1; req_type = t; req_arg0 = a0; req_arg1 = a1; req_len = len; req_hs = hs;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R10 ready after reset", 32'(req_ready), 1);
    chk({hs_dat_valid, lp_dat_valid, hs_ctl_valid, lp_ctl_valid, req_err} === 5'b0,
        "R10 idle outputs after reset",
        32'({hs_dat_valid, lp_dat_valid, hs_ctl_valid, lp_ctl_valid, req_err}), 0);
  endtask

  task automatic t_short(input logic [5:0] t, input logic [7:0] a0, input logic [7:0] a1,
                         input bit hs, input logic [31:0] exp, input bit hold);
    int c0 = ccnt, d0 = dcnt;
    if (hold) begin hs_ctl_ready = 0; lp_ctl_ready = 0; end
    issue(t, a0, a1, 16'd9, hs);
    chk(req_ready === 1'b0, "R10 ready low after accept", 32'(req_ready), 0);
    if (hold) begin
      logic [31:0] w0 = ctl_word;
      repeat (3) @(negedge clk);
      chk((hs ? hs_ctl_valid : lp_ctl_valid) && ctl_word == w0,
          "R12 header held under back-pressure", ctl_word, w0);
      hs_ctl_ready = 1; lp_ctl_ready = 1;
    end
    while (ccnt == c0) @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready back after header", 32'(req_ready), 1);
    chk(cw[c0] == exp, "R1 R2 R3 R8 short header", cw[c0], exp);
    chk(cp[c0] == hs, "R9 short path", 32'(cp[c0]), 32'(hs));
    chk(dcnt == d0, "R7 short has no data words", dcnt, d0);
  endtask

  task automatic t_long(input logic [5:0] t, input int len, input bit hs,
                        input logic [7:0] seed, input bit st);
    int c0 = ccnt, d0 = dcnt, nw = (len + 3) / 4;
    stall = st;
    issue(t, 8'h5A, 8'hA5, 16'(len), hs);
    for (int i = 0; i < len; i++) begin
      pay_valid = 1; pay_byte = pbyte(seed, i);
      while (!pay_ready) @(negedge clk);
      @(negedge clk);
    end
    pay_valid = 0;
    while (ccnt == c0) @(negedge clk);
    stall = 0;
    chk(dcnt - d0 == nw, "R6 word count", dcnt - d0, nw);
    for (int k = 0; k < nw && k < dcnt - d0; k++) begin
      chk(dw[d0 + k] == exp_word(seed, len, k), "R5 R6 payload word", dw[d0 + k], exp_word(seed, len, k));
      chk(dp[d0 + k] == hs, "R9 payload path", 32'(dp[d0 + k]), 32'(hs));
    end
    chk(cd[c0] == d0 + nw, "R7 header after all payload", cd[c0], d0 + nw);
    chk(cw[c0] == {8'h00, 16'(len), 2'b00, t}, "R4 R8 long header", cw[c0], {8'h00, 16'(len), 2'b00, t});
    chk(cp[c0] == hs, "R9 header path", 32'(cp[c0]), 32'(hs));
  endtask

  task automatic t_reject(input logic [5:0] t, input logic [15:0] len);
    int c0 = ccnt, d0 = dcnt;
    issue(t, 8'h11, 8'h22, len, 1'b1);
    chk(req_err === 1'b1, "R11 error pulse", 32'(req_err), 1);
    chk(req_ready === 1'b1, "R11 still ready", 32'(req_ready), 1);
    @(negedge clk);
    chk(req_err === 1'b0, "R11 pulse is one cycle", 32'(req_err), 0);
    repeat (3) @(negedge clk);
    chk(ccnt == c0 && dcnt == d0, "R11 no FIFO writes", ccnt + dcnt, c0 + d0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_short(6'h03, 8'hAB, 8'hCD, 1, 32'h0000_0003, 0);
    t_short(6'h14, 8'h3C, 8'h77, 0, 32'h0000_3C14, 0);
    t_short(6'h05, 8'h11, 8'h99, 1, 32'h0000_1105, 0);
    t_short(6'h06, 8'h0A, 8'hEE, 0, 32'h0000_0A06, 0);
    t_short(6'h23, 8'h12, 8'h34, 0, 32'h0034_1223, 1);
    t_short(6'h15, 8'h36, 8'h48, 1, 32'h0048_3615, 0);
    t_long(6'h39, 8, 1, 8'h10, 0);
    t_long(6'h29, 5, 0, 8'h40, 0);
    t_long(6'h39, 6, 1, 8'h80, 1);
    t_long(6'h29, 7, 0, 8'hC3, 1);
    t_long(6'h29, 1, 1, 8'hF0, 0);
    t_reject(6'h39, 16'd0);
    t_reject(6'h07, 16'd4);
    t_short(6'h24, 8'h01, 8'h02, 1, 32'h0002_0124, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule